// File: doc/BRIEF.md
# Associative Memory Road Finder

This block keeps a bank of pre-computed track patterns. Each pattern stores one coarse position word for each detector layer. While an event is open, every hit carries a layer number and a position word. The hit is compared, in the same cycle, against that layer's word in every stored pattern. Each pattern keeps one sticky flag per layer, which records that the layer was matched at least once during the event.

When the event is closed, the block scans the patterns. It reports each one, called a road, whose count of matched layers reaches a programmable threshold. Roads leave one per beat on a valid/ready stream in rising pattern index, and a marker beat ends the list.

The bank can be rewritten between events, so it can follow changes in alignment, detector conditions or beam position. One instance serves one event at a time. Overlapping events are handled by separate instances, each fed the hits that carry its own time stamp.

Top module: `am_road_finder`

## Requirements
- R1: A bank write (`cfg_wr`, `cfg_pat`, `cfg_layer`, `cfg_word`) takes effect only while no event is open and no roads are pending; writes at other times are ignored.
- R2: A pulse on `ev_open` while idle or during an event clears all layer flags and opens an event; `hit_ready` is 1 from the next cycle.
- R3: An accepted hit sets the flag of layer `hit_layer` in every pattern whose word for that same layer equals `hit_word`; the same word stored in another layer does not count.
- R4: Layer flags stay set for the rest of the event, so hits on different layers accumulate, and repeated hits change nothing.
- R5: A pattern is a road when its number of set layer flags is at least the threshold; the threshold resets to 3.
- R6: After `ev_close`, roads appear from the next cycle in ascending pattern index, one per accepted beat (`road_valid` and `road_ready` both 1). They are followed by exactly one marker beat with `road_end`=1 and `road_pat`=0.
- R7: `hit_ready` is 0 while roads are being emitted and while no event is open, so hits are held back and never lost.
- R8: While `road_valid` is 1 and `road_ready` is 0, `road_pat` and `road_end` hold their values.
- R9: `thr_wr` loads `thr_val` into the threshold only while idle; a threshold of 4 requires all four layers.
- R10: Once the marker beat is accepted, the block is idle: `road_valid` and `hit_ready` are 0 until the next `ev_open`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Bank word write strobe |
| cfg_pat | input | PW | Pattern index to write |
| cfg_layer | input | LW | Layer index to write |
| cfg_word | input | WW | Position word to store |
| thr_wr | input | 1 | Threshold write strobe |
| thr_val | input | CW | New layer-count threshold |
| ev_open | input | 1 | Start-of-event pulse |
| ev_close | input | 1 | End-of-event pulse |
| hit_valid | input | 1 | Hit present |
| hit_ready | output | 1 | Hit accepted this cycle when valid |
| hit_layer | input | LW | Layer of the hit |
| hit_word | input | WW | Coarse position of the hit |
| road_valid | output | 1 | Road beat present |
| road_ready | input | 1 | Consumer takes the beat |
| road_pat | output | PW | Matched pattern index (0 on marker) |
| road_end | output | 1 | Marker beat closing the road list |

## Verification
A hit accepted on a clock edge sets its flags on that same edge. A beat with `ev_close` moves the block to road output on that edge, so the first road or the marker is valid in the cycle right after. Each accepted beat shows the next road or the marker in the following cycle.

The bench drives inputs on the falling edge, which places `ev_close` one cycle after the last hit. It reads `hit_ready` and the road stream on the falling edge, half a cycle after the edge that updated them. Each road is therefore compared in exactly the cycle it is due. Stalls are inserted on the road stream to check that outputs hold and that hits stay blocked.

// File: rtl/am_road_finder.sv
module am_road_finder #(
  parameter int NPAT = 128,
  parameter int NL   = 4,
  parameter int WW   = 12,
  parameter int PW   = $clog2(NPAT),
  parameter int LW   = $clog2(NL),
  parameter int CW   = $clog2(NL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [PW-1:0] cfg_pat,
  input  logic [LW-1:0] cfg_layer,
  input  logic [WW-1:0] cfg_word,
  input  logic          thr_wr,
  input  logic [CW-1:0] thr_val,
  input  logic          ev_open,
  input  logic          ev_close,
  input  logic          hit_valid,
  output logic          hit_ready,
  input  logic [LW-1:0] hit_layer,
  input  logic [WW-1:0] hit_word,
  output logic          road_valid,
  input  logic          road_ready,
  output logic [PW-1:0] road_pat,
  output logic          road_end
);

  typedef enum logic [1:0] {S_IDLE, S_EVENT, S_EMIT} state_t;

  state_t        st;
  logic [WW-1:0] bank [NPAT][NL];
  logic [NL-1:0] flg  [NPAT];
  logic [CW-1:0] thr;
  logic [PW:0]   cursor;
  logic [NPAT-1:0] is_road;
  logic          found;
  logic [PW-1:0] found_idx;

  wire hit_fire  = hit_valid && hit_ready;
  wire road_fire = road_valid && road_ready;

  assign hit_ready  = (st == S_EVENT);
  assign road_valid = (st == S_EMIT);
  assign road_end   = road_valid && !found;
  assign road_pat   = found ? found_idx : '0;

  always_comb begin
    for (int p = 0; p < NPAT; p++)
      is_road[p] = ($countones(flg[p]) >= int'(thr));
  end

  always_comb begin
    found     = 1'b0;
    found_idx = '0;
    for (int p = NPAT - 1; p >= 0; p--)
      if (is_road[p] && (p >= int'(cursor))) begin
        found     = 1'b1;
        found_idx = PW'(p);
      end
  end

  always_ff @(posedge clk)
    if (cfg_wr && st == S_IDLE)
      bank[cfg_pat][cfg_layer] <= cfg_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      thr    <= CW'(3);
      cursor <= '0;
      for (int p = 0; p < NPAT; p++) flg[p] <= '0;
    end else begin
      if (thr_wr && st == S_IDLE) thr <= thr_val;
      case (st)
        S_IDLE, S_EVENT: begin
          if (ev_open) begin
            st <= S_EVENT;
            for (int p = 0; p < NPAT; p++) flg[p] <= '0;
          end else if (st == S_EVENT) begin
            if (hit_fire)
              for (int p = 0; p < NPAT; p++)
                if (bank[p][hit_layer] == hit_word) flg[p][hit_layer] <= 1'b1;
            if (ev_close) begin
              st     <= S_EMIT;
              cursor <= '0;
            end
          end
        end
        S_EMIT: begin
          if (road_fire) begin
            if (found) cursor <= {1'b0, found_idx} + 1'b1;
            else       st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_hold_hits: assert property (@(posedge clk) disable iff (!rst_n)
    road_valid |-> !hit_ready);

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (road_fire && !road_end) |=> (!road_valid || road_end || road_pat > $past(road_pat)));

  a_r6_marker_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && road_end) |-> road_pat == '0);

  a_r8_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && !road_ready) |=> (road_valid && $stable(road_pat) && $stable(road_end)));

  a_r10_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (road_fire && road_end) |=> (!road_valid && !hit_ready));

  a_r2_open: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_open && !road_valid) |=> hit_ready);

endmodule

// File: tb/test_am_road_finder.sv
module test_am_road_finder;
  localparam int NPAT = 16, NL = 4, WW = 12;
  localparam int PW = $clog2(NPAT), LW = $clog2(NL), CW = $clog2(NL + 1);

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, thr_wr = 0, ev_open = 0, ev_close = 0, hit_valid = 0, road_ready = 0;
  logic [PW-1:0] cfg_pat = '0;
  logic [LW-1:0] cfg_layer = '0, hit_layer = '0;
  logic [WW-1:0] cfg_word = '0, hit_word = '0;
  logic [CW-1:0] thr_val = '0;
  logic hit_ready, road_valid, road_end;
  logic [PW-1:0] road_pat;

  int total = 0, bad = 0, cyc = 0;
  logic [WW-1:0] mbank [NPAT][NL];
  logic [NL-1:0] mflg [NPAT];
  int mthr = 3;
  int got [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  am_road_finder #(.NPAT(NPAT), .NL(NL), .WW(WW)) i_am_road_finder (
    .clk, .rst_n, .cfg_wr, .cfg_pat, .cfg_layer, .cfg_word, .thr_wr, .thr_val,
    .ev_open, .ev_close, .hit_valid, .hit_ready, .hit_layer, .hit_word,
    .road_valid, .road_ready, .road_pat, .road_end);

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] wd(int p, int l);
    return WW'(100 + p * 8 + l);
  endfunction

  task automatic wr(int p, int l, logic [WW-1:0] w, bit model);
    @(negedge clk);
    cfg_wr = 1; cfg_pat = PW'(p); cfg_layer = LW'(l); cfg_word = w;
    @(negedge clk);
    cfg_wr = 0;
    if (model) mbank[p][l] = w;
  endtask

  task automatic set_thr(int t);
    @(negedge clk);
    thr_wr = 1; thr_val = CW'(t);
    @(negedge clk);
    thr_wr = 0; mthr = t;
  endtask

  task automatic open_ev;
    @(negedge clk);
    ev_open = 1;
    @(negedge clk);
    ev_open = 0;
    check("R2 hit_ready after open", int'(hit_ready), 1);
    for (int p = 0; p < NPAT; p++) mflg[p] = '0;
  endtask

  task automatic hit(int l, logic [WW-1:0] w);
    hit_valid = 1; hit_layer = LW'(l); hit_word = w;
    @(negedge clk);
    hit_valid = 0;
    for (int p = 0; p < NPAT; p++) if (mbank[p][l] == w) mflg[p][l] = 1'b1;
  endtask

  task automatic close_and_collect(string req, int stall);
    int pv = 0, pa = 0, pe = 0, guard = 0;
    int exp [$];
    bit done = 0;
    ev_close = 1;
    @(negedge clk);
    ev_close = 0;
    got.delete();
    while (!done && guard < 200) begin
      guard++;
      road_ready = (stall != 0) ? ((guard % stall) == 0) : 1'b1;
      if (road_valid) check("R7 hit_ready low while emitting", int'(hit_ready), 0);
      if (pv != 0) begin
        check("R8 road_pat held on stall", int'(road_pat), pa);
        check("R8 road_end held on stall", int'(road_end), pe);
      end
      pv = int'(road_valid && !road_ready); pa = int'(road_pat); pe = int'(road_end);
      if (road_valid && road_ready) begin
        if (road_end) begin
          check("R6 marker carries index 0", int'(road_pat), 0);
          done = 1;
        end else got.push_back(int'(road_pat));
      end
      @(negedge clk);
    end
    road_ready = 0;
    check("R6 marker reached", int'(done), 1);
    check("R10 idle road_valid", int'(road_valid), 0);
    check("R10 idle hit_ready", int'(hit_ready), 0);
    for (int p = 0; p < NPAT; p++) if ($countones(mflg[p]) >= mthr) exp.push_back(p);
    check({req, " road count"}, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      check({req, " road index"}, got[i], exp[i]);
  endtask

  task automatic t_reset;
    check("R10 reset hit_ready", int'(hit_ready), 0);
    check("R10 reset road_valid", int'(road_valid), 0);
  endtask

  task automatic t_basic(string req, int stall);
    open_ev();
    for (int l = 0; l < 3; l++) hit(l, wd(3, l));
    for (int l = 0; l < 4; l++) hit(l, wd(5, l));
    hit(0, wd(7, 0)); hit(1, wd(7, 1));
    hit(0, wd(3, 0)); hit(0, wd(3, 0));
    close_and_collect(req, stall);
  endtask

  task automatic t_write_during_event;
    open_ev();
    wr(2, 0, 12'hABC, 0);
    hit(0, wd(2, 0)); hit(1, wd(2, 1)); hit(2, wd(2, 2));
    close_and_collect("R1 write ignored during event", 0);
    check("R1 road 2 from old word", (got.size() > 0) ? got[0] : -1, 2);
  endtask

  task automatic t_wrong_layer;
    open_ev();
    hit(1, wd(4, 0)); hit(2, wd(4, 2)); hit(3, wd(4, 3));
    close_and_collect("R3 layer must match", 0);
    check("R3 no road from wrong layer", got.size(), 0);
  endtask

  task automatic t_shared;
    for (int l = 0; l < 4; l++) begin
      wr(10, l, WW'(3000 + l), 1);
      wr(11, l, WW'(3000 + l), 1);
    end
    open_ev();
    for (int l = 0; l < 3; l++) hit(l, WW'(3000 + l));
    hit(3, wd(9, 3));
    close_and_collect("R3 one hit matches many patterns", 1);
    check("R3 two roads", got.size(), 2);
  endtask

  task automatic t_clear;
    open_ev();
    for (int l = 0; l < 4; l++) hit(l, wd(6, l));
    open_ev();
    hit(0, wd(6, 0));
    close_and_collect("R2 flags cleared on open", 0);
    check("R2 nothing left over", got.size(), 0);
  endtask

  task automatic t_held_hits;
    open_ev();
    for (int l = 0; l < 4; l++) hit(l, wd(1, l));
    ev_close = 1;
    @(negedge clk);
    ev_close = 0;
    hit_valid = 1; hit_layer = 0; hit_word = wd(1, 0);
    check("R7 hit held back while emitting", int'(hit_ready), 0);
    check("R6 first road due next cycle", int'(road_valid), 1);
    check("R6 first road index", int'(road_pat), 1);
    road_ready = 1;
    @(negedge clk);
    check("R6 marker after last road", int'(road_end), 1);
    @(negedge clk);
    road_ready = 0;
    check("R7 hit still blocked when idle", int'(hit_ready), 0);
    hit_valid = 0;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    for (int p = 0; p < NPAT; p++) for (int l = 0; l < NL; l++) wr(p, l, wd(p, l), 1);
    t_basic("R5 default threshold 3 and R4 accumulate", 0);
    check("R5 roads 3 and 5", got.size(), 2);
    t_basic("R8 stalled road stream", 3);
    set_thr(4);
    t_basic("R9 threshold 4", 0);
    check("R9 only full match", (got.size() == 1) ? got[0] : -1, 5);
    set_thr(3);
    t_write_during_event();
    t_wrong_layer();
    t_shared();
    t_clear();
    t_held_hits();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule